// File: doc/BRIEF.md
# All-Ones Alarm Detector for Serial Tributaries

This block watches seven demultiplexed serial tributary bit streams and flags each one that is carrying an all-ones alarm pattern. Every lane has its own bit-valid strobe. The block counts only the bits that arrive with the strobe high, and groups them into fixed windows of `WIN_LEN` bits (840 by default). The windows sit back to back and never overlap. A window is alarm-like when it contains no more than `ZERO_TOL` zeros (4 by default). In other words, it is alarm-like when it has fewer than five zeros.

A persistence rule sits behind the per-window decision. The alarm sets only after `PERSIST` consecutive windows (2 by default) have all been alarm-like. It clears only after the same number of consecutive windows have each exceeded the zero tolerance. Any other mix of windows leaves the alarm where it was. Each lane runs independently of the others. Clock recovery, demultiplexing and register access belong to the surrounding logic.

Top module: `aod_top`

## Requirements
- R1: While rst_ni is low, alarm_o is all zeros. After reset is released, each lane starts a fresh window with no window history.
- R2: A window is exactly WIN_LEN bits for which valid_i[lane] is 1. Cycles where valid_i[lane] is 0 neither advance the window nor count zeros, whatever data_i[lane] holds.
- R3: A window is alarm-like when the number of zero bits among its valid bits is at most ZERO_TOL. With the default of 4, five or more zeros make it non-alarm-like.
- R4: alarm_o[lane] goes to 1 on the clock edge that samples the last valid bit of a window, provided that window and the one before it were both alarm-like.
- R5: alarm_o[lane] goes to 0 on the clock edge that samples the last valid bit of a window, provided that window and the one before it each held more than ZERO_TOL zeros.
- R6: alarm_o[lane] changes only on a window-closing edge. If the two most recent windows disagree, alarm_o[lane] keeps its value.
- R7: Each lane's window position, zero count, history and alarm depend only on that lane's data_i and valid_i bits. Bit index n of every vector belongs to lane n.
- R8: Windows are consecutive and do not overlap. After reset, the first window is only ever judged together with the window that follows it, never alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | NUM_LANES | Serial data bit per lane |
| valid_i | input | NUM_LANES | Bit-valid strobe per lane |
| alarm_o | output | NUM_LANES | All-ones alarm status per lane |

## Verification
The bench builds the block with seven lanes, the default tolerance of four zeros and the default two-window persistence, but with WIN_LEN reduced to 20. The short window brings many complete window pairs within a few thousand cycles. That covers set, clear and mixed pairs on every lane, including the exact four-versus-five zero boundary and reset in mid-window. Valid gaps carrying zeros show that strobed-off bits are skipped. Per-lane zero densities that straddle the tolerance make the lanes diverge from one another.

// File: rtl/aod_pkg.sv
package aod_pkg;
  localparam int unsigned DEF_LANES    = 7;
  localparam int unsigned DEF_WIN_LEN  = 840;
  localparam int unsigned DEF_ZERO_TOL = 4;
  localparam int unsigned DEF_PERSIST  = 2;

  typedef struct packed {
    logic win_end;
    logic like;
  } win_res_t;
endpackage

// File: rtl/aod_win_ctr.sv
module aod_win_ctr #(
  parameter int unsigned WIN_LEN = aod_pkg::DEF_WIN_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic win_end_o
);
  localparam int unsigned CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign win_end_o = valid_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else if (valid_i)   cnt_q <= cnt_q + 1'b1;
  end

  // R2
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
  // R8
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/aod_zero_ctr.sv
module aod_zero_ctr #(
  parameter int unsigned ZERO_TOL = aod_pkg::DEF_ZERO_TOL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  input  logic win_end_i,
  output logic like_o
);
  localparam int unsigned SAT = ZERO_TOL + 1;
  localparam int unsigned ZW  = $clog2(SAT + 1);
  localparam logic [ZW-1:0] SAT_V = ZW'(SAT);
  localparam logic [ZW-1:0] TOL_V = ZW'(ZERO_TOL);

  logic [ZW-1:0] zcnt_q, zcnt_nx;

  // zero count including the current bit, saturating
  always_comb begin
    zcnt_nx = zcnt_q;
    if (valid_i && !bit_i && zcnt_q != SAT_V) zcnt_nx = zcnt_q + 1'b1;
  end

  assign like_o = (zcnt_nx <= TOL_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        zcnt_q <= '0;
    else if (win_end_i) zcnt_q <= '0;
    else                zcnt_q <= zcnt_nx;
  end

  // R3
  zero_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zcnt_q <= SAT_V);
  // R2
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !win_end_i) |=> $stable(zcnt_q));
endmodule

// File: rtl/aod_persist.sv
module aod_persist #(
  parameter int unsigned PERSIST = aod_pkg::DEF_PERSIST
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_end_i,
  input  logic like_i,
  output logic alarm_o
);
  localparam int unsigned HW = (PERSIST > 1) ? PERSIST - 1 : 1;
  localparam int unsigned SW = $clog2(HW + 1);
  localparam logic [SW-1:0] FULL = SW'(HW);

  logic [HW-1:0] hist_q;
  logic [SW-1:0] seen_q;
  logic          alarm_q;
  logic          full, do_set, do_clr;

  assign full   = (seen_q == FULL);
  assign do_set = win_end_i && full && like_i && (&hist_q);
  assign do_clr = win_end_i && full && !like_i && !(|hist_q);

  generate
    if (HW == 1) begin : g_hist1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        hist_q <= '0;
        else if (win_end_i) hist_q <= like_i;
      end
    end else begin : g_histn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        hist_q <= '0;
        else if (win_end_i) hist_q <= {hist_q[HW-2:0], like_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (win_end_i && !full) seen_q <= seen_q + 1'b1;
      if (do_set)      alarm_q <= 1'b1;
      else if (do_clr) alarm_q <= 1'b0;
    end
  end

  assign alarm_o = alarm_q;

  // R4
  set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_q) |-> $past(win_end_i && like_i));
  // R5
  clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_q) |-> $past(win_end_i && !like_i));
  // R6
  only_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(alarm_q));
  // R8
  no_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == '0) |=> !alarm_q);
endmodule

// File: rtl/aod_lane.sv
module aod_lane #(
  parameter int unsigned WIN_LEN  = aod_pkg::DEF_WIN_LEN,
  parameter int unsigned ZERO_TOL = aod_pkg::DEF_ZERO_TOL,
  parameter int unsigned PERSIST  = aod_pkg::DEF_PERSIST
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic valid_i,
  output logic alarm_o
);
  aod_pkg::win_res_t res;

  aod_win_ctr #(.WIN_LEN(WIN_LEN)) win_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .win_end_o(res.win_end)
  );

  aod_zero_ctr #(.ZERO_TOL(ZERO_TOL)) zero_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .bit_i    (data_i),
    .win_end_i(res.win_end),
    .like_o   (res.like)
  );

  aod_persist #(.PERSIST(PERSIST)) pers_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_end_i(res.win_end),
    .like_i   (res.like),
    .alarm_o  (alarm_o)
  );
endmodule

// File: rtl/aod_top.sv
module aod_top #(
  parameter int unsigned NUM_LANES = aod_pkg::DEF_LANES,
  parameter int unsigned WIN_LEN   = aod_pkg::DEF_WIN_LEN,
  parameter int unsigned ZERO_TOL  = aod_pkg::DEF_ZERO_TOL,
  parameter int unsigned PERSIST   = aod_pkg::DEF_PERSIST
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] data_i,
  input  logic [NUM_LANES-1:0] valid_i,
  output logic [NUM_LANES-1:0] alarm_o
);
  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      aod_lane #(
        .WIN_LEN (WIN_LEN),
        .ZERO_TOL(ZERO_TOL),
        .PERSIST (PERSIST)
      ) lane_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .data_i (data_i[l]),
        .valid_i(valid_i[l]),
        .alarm_o(alarm_o[l])
      );
    end
  endgenerate

  // R7
  lane_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) |=> $stable(alarm_o));
endmodule

// File: tb/aod_top_tb_top.sv
module aod_top_tb_top;
  localparam int L   = 7;
  localparam int WIN = 20;
  localparam int TOL = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [L-1:0] data_i = '1;
  logic [L-1:0] valid_i = '0;
  logic [L-1:0] alarm_o;

  always #2 clk = ~clk;

  aod_top #(.NUM_LANES(L), .WIN_LEN(WIN), .ZERO_TOL(TOL), .PERSIST(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .valid_i(valid_i), .alarm_o(alarm_o)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string phase = "R1";

  int   m_cnt[L];
  int   m_zero[L];
  bit   m_prev[L];
  bit   m_seen[L];
  logic [L-1:0] m_alarm;

  task automatic model_reset();
    for (int l = 0; l < L; l++) begin
      m_cnt[l] = 0; m_zero[l] = 0; m_prev[l] = 0; m_seen[l] = 0;
    end
    m_alarm = '0;
  endtask

  task automatic model_step(input logic [L-1:0] d, input logic [L-1:0] v);
    for (int l = 0; l < L; l++) begin
      if (v[l]) begin
        int z = m_zero[l] + (d[l] ? 0 : 1);
        if (m_cnt[l] == WIN - 1) begin
          bit like = (z <= TOL);
          if (m_seen[l] && like && m_prev[l])   m_alarm[l] = 1'b1;
          if (m_seen[l] && !like && !m_prev[l]) m_alarm[l] = 1'b0;
          m_prev[l] = like; m_seen[l] = 1; m_cnt[l] = 0; m_zero[l] = 0;
        end else begin
          m_cnt[l]++; m_zero[l] = z;
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t alarm_o act=%b exp=%b", req, $time, act, exp);
    end
  endtask

  // check previous edge result, then apply new inputs
  task automatic step(input logic [L-1:0] d, input logic [L-1:0] v);
    @(negedge clk);
    check(phase, alarm_o, m_alarm);
    data_i = d; valid_i = v;
    model_step(d, v);
  endtask

  // lane l emits nz[l] zeros at the start of each window
  task automatic windows_with_zeros(input int nz[L], input int nwin);
    for (int c = 0; c < nwin * WIN; c++) begin
      logic [L-1:0] d;
      for (int l = 0; l < L; l++) d[l] = !(m_cnt[l] < nz[l]);
      step(d, '1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid_i = '0; data_i = '1;
    model_reset();
    @(negedge clk);
    check("R1", alarm_o, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nz[L];
    void'($urandom(32'h5eed_0aad));
    model_reset();
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", alarm_o, '0);
    rst_n = 1'b1;

    // R8: a single all-ones window must not set
    phase = "R8";
    for (int l = 0; l < L; l++) nz[l] = 0;
    windows_with_zeros(nz, 1);
    step('1, '0);
    check("R8", alarm_o, '0);

    // R4: second clean window sets on its last bit
    phase = "R4";
    windows_with_zeros(nz, 1);
    step('1, '0);
    check("R4", alarm_o, '1);

    // R3/R7: lane l sees l zeros per window
    phase = "R3";
    for (int l = 0; l < L; l++) nz[l] = l;
    windows_with_zeros(nz, 2);
    step('1, '0);
    check("R7", alarm_o, 7'b0011111);

    // R5: five zeros everywhere clears all
    phase = "R5";
    for (int l = 0; l < L; l++) nz[l] = 5;
    windows_with_zeros(nz, 2);
    step('1, '0);
    check("R5", alarm_o, '0);

    // R6: alternate like / non-like windows, alarm stays low
    phase = "R6";
    for (int w = 0; w < 4; w++) begin
      for (int l = 0; l < L; l++) nz[l] = (w % 2 == 0) ? 4 : 6;
      windows_with_zeros(nz, 1);
    end
    step('1, '0);
    check("R6", alarm_o, '0);
    for (int l = 0; l < L; l++) nz[l] = 0;
    windows_with_zeros(nz, 2);
    for (int w = 0; w < 3; w++) begin
      for (int l = 0; l < L; l++) nz[l] = (w % 2 == 0) ? 9 : 1;
      windows_with_zeros(nz, 1);
    end
    step('1, '0);
    check("R6", alarm_o, '1);

    // R2: zeros on strobed-off cycles are ignored
    phase = "R2";
    for (int c = 0; c < 4 * WIN; c++) begin
      step('0, '0);
      step('1, '1);
    end
    step('1, '0);
    check("R2", alarm_o, '1);

    // R1: reset mid-window starts fresh
    phase = "R1";
    for (int c = 0; c < WIN / 2; c++) step('0, '1);
    do_reset();
    for (int l = 0; l < L; l++) nz[l] = 0;
    windows_with_zeros(nz, 2);
    step('1, '0);
    check("R1", alarm_o, '1);

    // R8: random densities and strobes per lane
    phase = "R8";
    for (int blk = 0; blk < 40; blk++) begin
      int pz[L];
      int pv[L];
      for (int l = 0; l < L; l++) begin
        pz[l] = $urandom_range(0, 3) == 0 ? 40 : $urandom_range(0, 3);
        pv[l] = $urandom_range(60, 100);
      end
      for (int c = 0; c < 3 * WIN; c++) begin
        logic [L-1:0] d, v;
        for (int l = 0; l < L; l++) begin
          d[l] = !($urandom_range(0, 99) < pz[l]);
          v[l] = ($urandom_range(0, 99) < pv[l]);
        end
        step(d, v);
      end
    end
    step('1, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule